// File: doc/BRIEF.md
# Reset Cause and Suspend Controller

This block holds a single byte-wide control and status register. The register records which event last reset the device, and the block manages a low-power suspend state around it. Software writes the register to enter suspend, to clear recorded reset causes and to set a run bit. It reads the same register back on a combinational port. The power-on event is the block's own active-low reset. Watchdog and bus-reset events arrive as single-cycle pulses.

After power-on the block sits in suspend with the oscillator and timer enable low. In this first suspend only bus activity can wake it. Later, software can enter suspend again, and then bus activity, a GPIO interrupt or an RC-pin interrupt ends it. When suspend ends, the oscillator enable rises at once. A settling count of 256 one-microsecond ticks then runs before the core is reported ready. The core-run output is high only when the run bit is set and the core is ready.

Top module: `rss_ctrl`

## Requirements
- R1: After reset the register reads 8'h19 (power-on flag at bit 4, suspend at bit 3 and run at bit 0 set). `osc_en`, `core_ready` and `core_run` are low.
- R2: In the suspend left by reset, `gpio_wake` and `rcpin_wake` have no effect. `bus_active` ends that suspend, and after it the GPIO and RC-pin wakes are honoured.
- R3: Writing with bit 3 set while not suspended sets bit 3 after the write's clock edge. From the same edge `osc_en` and `core_ready` are low.
- R4: While suspended, any one of `bus_active`, `gpio_wake` or `rcpin_wake` clears bit 3 at the next edge, and `osc_en` goes high on that same edge.
- R5: Once suspend has ended, `core_ready` rises on the edge that samples the 256th high `tick_us` and not before. Suspend clears the partial count.
- R6: A `wdog_evt` pulse sets bit 6 and a `busrst_evt` pulse sets bit 5. An event wins over a clearing write in the same cycle.
- R7: Writing 0 to flag bit 6, 5 or 4 clears that flag. Writing 1 leaves it unchanged.
- R8: Bits 7, 2 and 1 always read 0, whatever is written.
- R9: Bit 0 is a plain read/write run bit. `core_run` is high exactly when bit 0 and `core_ready` are both high.
- R10: A suspend write with a wake request high in the same cycle still leaves bit 3 set for one cycle. Suspend then ends on the next edge.
- R11: While not suspended, wake inputs have no effect, and writing 0 to bit 3 does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert, synchronized release |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| wdog_evt | input | 1 | Watchdog reset event pulse |
| busrst_evt | input | 1 | Bus reset event pulse |
| bus_active | input | 1 | Non-idle bus state (wake) |
| gpio_wake | input | 1 | GPIO interrupt wake request |
| rcpin_wake | input | 1 | RC-pin interrupt wake request |
| tick_us | input | 1 | One-microsecond tick, one cycle wide |
| osc_en | output | 1 | Oscillator and timer enable |
| core_run | output | 1 | Core run (high) or hold (low) |
| core_ready | output | 1 | Settling delay after wake has elapsed |

## Verification
The wake logic is tried with each wake source on its own, in both the suspend left by reset and a suspend that software entered. This separates the bus-only lock from the general wake path. Random sequences of flag writes, run writes, event pulses and stray wake requests are compared with a reference model of the register while the block is awake. These sequences expose priority errors between events and clears, and any leak of wakes into the awake state. Directed cases cover a suspend write with a wake request in the same cycle, and the exact tick on which ready rises. They also cover a settling count cut short by suspend, and a second reset in the middle of the run.

// File: rtl/rss_pkg.sv
package rss_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned POS_WDOG = 6;
  localparam int unsigned POS_BUS  = 5;
  localparam int unsigned POS_POR  = 4;
  localparam int unsigned POS_SUSP = 3;
  localparam int unsigned POS_RUN  = 0;
  localparam int unsigned FLAG_N   = 3;
endpackage

// File: rtl/rss_sticky.sv
module rss_sticky #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic q_o
);
  logic q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (wr_i && !wbit_i) q_d = 1'b0;
    if (set_i)           q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= RST_VAL;
    else        q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/rss_susp.sv
module rss_susp (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_susp,
  input  logic bus_act,
  input  logic gpio_req,
  input  logic rc_req,
  output logic susp_q,
  output logic susp_d
);
  logic lock_q, lock_d;
  logic wake;
  logic s_q;

  always_comb begin
    wake   = bus_act || (!lock_q && (gpio_req || rc_req));
    lock_d = lock_q && !(s_q && bus_act);
    if (s_q) susp_d = !wake;
    else     susp_d = wr_en && wr_susp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q    <= 1'b1;
      lock_q <= 1'b1;
    end else begin
      s_q    <= susp_d;
      lock_q <= lock_d;
    end
  end

  assign susp_q = s_q;
endmodule

// File: rtl/rss_settle.sv
module rss_settle #(
  parameter int unsigned TICKS = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  input  logic tick_i,
  output logic rdy_o
);
  localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          rdy_q, rdy_d;

  always_comb begin
    cnt_d = cnt_q;
    rdy_d = rdy_q;
    if (hold_i) begin
      cnt_d = '0;
      rdy_d = 1'b0;
    end else if (tick_i && !rdy_q) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        rdy_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign rdy_o = rdy_q;
endmodule

// File: rtl/rss_ctrl.sv
module rss_ctrl
  import rss_pkg::*;
#(
  parameter int unsigned SETTLE_TICKS = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             wdog_evt,
  input  logic             busrst_evt,
  input  logic             bus_active,
  input  logic             gpio_wake,
  input  logic             rcpin_wake,
  input  logic             tick_us,
  output logic             osc_en,
  output logic             core_run,
  output logic             core_ready
);
  localparam int unsigned FPOS [FLAG_N] = '{POS_WDOG, POS_BUS, POS_POR};
  localparam logic [FLAG_N-1:0] FRST    = 3'b001;

  logic [FLAG_N-1:0] flag_set;
  logic [FLAG_N-1:0] flag_q;
  logic              susp_q, susp_d;
  logic              run_q, run_d;
  logic              rdy;

  assign flag_set = {wdog_evt, busrst_evt, 1'b0};

  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    rss_sticky #(.RST_VAL(FRST[FLAG_N-1-g])) i_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (flag_set[FLAG_N-1-g]),
      .wr_i   (wr_en),
      .wbit_i (wr_data[FPOS[g]]),
      .q_o    (flag_q[FLAG_N-1-g])
    );
  end

  rss_susp i_susp (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_susp  (wr_data[POS_SUSP]),
    .bus_act  (bus_active),
    .gpio_req (gpio_wake),
    .rc_req   (rcpin_wake),
    .susp_q   (susp_q),
    .susp_d   (susp_d)
  );

  rss_settle #(.TICKS(SETTLE_TICKS)) i_settle (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold_i (susp_d),
    .tick_i (tick_us),
    .rdy_o  (rdy)
  );

  always_comb begin
    run_d = run_q;
    if (wr_en) run_d = wr_data[POS_RUN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b1;
    else        run_q <= run_d;
  end

  always_comb begin
    rd_data           = '0;
    rd_data[POS_WDOG] = flag_q[2];
    rd_data[POS_BUS]  = flag_q[1];
    rd_data[POS_POR]  = flag_q[0];
    rd_data[POS_SUSP] = susp_q;
    rd_data[POS_RUN]  = run_q;
  end

  assign osc_en     = !susp_q;
  assign core_ready = rdy;
  assign core_run   = run_q && rdy;
endmodule

// File: rtl/rss_ctrl_chk.sv
module rss_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       wdog_evt,
  input logic       busrst_evt,
  input logic       bus_active,
  input logic       gpio_wake,
  input logic       rcpin_wake,
  input logic       tick_us,
  input logic       osc_en,
  input logic       core_run,
  input logic       core_ready
);
  // R6
  wdog_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_evt |=> rd_data[6]);

  // R6
  busrst_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busrst_evt |=> rd_data[5]);

  // R3 R10
  susp_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[3] && !rd_data[3]) |=> rd_data[3]);

  // R5
  ready_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_ready |-> osc_en);

  // R5
  ready_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_ready) |-> $past(tick_us));

  // R7
  por_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[4] && !(wr_en && !wr_data[4])) |=> rd_data[4]);

  // R11
  awake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[3] && !(wr_en && wr_data[3])) |=> !rd_data[3]);
endmodule

bind rss_ctrl rss_ctrl_chk i_chk (.*);

// File: tb/test_rss_ctrl.sv
module test_rss_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       wdog_evt, busrst_evt, bus_active, gpio_wake, rcpin_wake, tick_us;
  logic       osc_en, core_run, core_ready;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  rss_ctrl i_rss_ctrl (.*);

  always #2 clk = ~clk;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 0; wr_data = 0; wdog_evt = 0; busrst_evt = 0;
    bus_active = 0; gpio_wake = 0; rcpin_wake = 0; tick_us = 0;
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1; wr_data = d; cyc(); wr_en = 0; wr_data = 0;
  endtask

  task automatic ticks(int n);
    tick_us = 1;
    for (int i = 0; i < n; i++) cyc();
    tick_us = 0;
  endtask

  function automatic logic [7:0] model(logic [7:0] cur, logic w, logic [7:0] d,
                                       logic wd, logic br);
    logic [7:0] r;
    r    = 8'h00;
    r[6] = wd | (cur[6] & ~(w & ~d[6]));
    r[5] = br | (cur[5] & ~(w & ~d[5]));
    r[4] = cur[4] & ~(w & ~d[4]);
    r[0] = w ? d[0] : cur[0];
    return r;
  endfunction

  task automatic do_reset();
    rst_n = 0; idle();
    repeat (3) cyc();
    rst_n = 1; cyc();
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp;
    void'($urandom(32'h5A17));
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1 reg", rd_data, 8'h19);
    check("R1 osc/ready/run", {5'b0, osc_en, core_ready, core_run}, 8'h00);

    // R2 GPIO and RC wake ignored after power-on
    gpio_wake = 1; repeat (3) cyc(); gpio_wake = 0;
    rcpin_wake = 1; repeat (3) cyc(); rcpin_wake = 0;
    check("R2 still suspended", rd_data, 8'h19);
    check("R2 osc off", {7'b0, osc_en}, 8'h00);
    bus_active = 1; cyc(); bus_active = 0;
    check("R2 R4 bus wake", rd_data, 8'h11);
    check("R4 osc on", {7'b0, osc_en}, 8'h01);

    // R5 ready on 256th tick
    ticks(255);
    check("R5 not ready at 255", {7'b0, core_ready}, 8'h00);
    ticks(1);
    check("R5 ready at 256", {7'b0, core_ready}, 8'h01);
    check("R9 core_run", {7'b0, core_run}, 8'h01);

    // R8 R11 reserved bits and susp write 0
    wr(8'hF7);
    check("R8 R11 reserved/susp0", rd_data, 8'h11);
    // R7 clear POR flag
    wr(8'h01);
    check("R7 clear por", rd_data, 8'h01);
    // R6 events
    wdog_evt = 1; cyc(); wdog_evt = 0;
    check("R6 wdog", rd_data, 8'h41);
    busrst_evt = 1; cyc(); busrst_evt = 0;
    check("R6 busrst", rd_data, 8'h61);
    wdog_evt = 1; wr(8'h01); wdog_evt = 0;
    check("R6 event beats clear", rd_data, 8'h41);
    // R9 run bit
    wr(8'h40);
    check("R9 run 0", {rd_data[0], core_run}, 8'h00);
    wr(8'h41);
    check("R9 run 1", {rd_data[0], core_run}, 8'h03);

    // random awake phase: R6 R7 R8 R9 R11
    exp = rd_data;
    for (int i = 0; i < 300; i++) begin
      logic       w, wd, br;
      logic [7:0] d;
      w = 1'($urandom); d = 8'($urandom) & 8'hF7;
      wd = ($urandom % 5) == 0; br = ($urandom % 5) == 0;
      wr_en = w; wr_data = d; wdog_evt = wd; busrst_evt = br;
      bus_active = 1'($urandom); gpio_wake = 1'($urandom); rcpin_wake = 1'($urandom);
      tick_us = 1'($urandom);
      exp = model(exp, w, d, wd, br);
      cyc();
      check("R6 R7 R8 R9 R11 random", rd_data, exp);
      check("R11 stays awake", {6'b0, osc_en, core_ready}, 8'h03);
    end
    idle();
    wr(8'h01);

    // R3 enter suspend, R4 each wake source
    wr(8'hF9);
    check("R3 susp set", rd_data, 8'h09);
    check("R3 osc/ready low", {6'b0, osc_en, core_ready}, 8'h00);
    gpio_wake = 1; cyc(); gpio_wake = 0;
    check("R4 gpio wake", {osc_en, rd_data[3]}, 8'h02);
    wr(8'h09);
    rcpin_wake = 1; cyc(); rcpin_wake = 0;
    check("R4 rc wake", {osc_en, rd_data[3]}, 8'h02);
    wr(8'h09);
    bus_active = 1; cyc(); bus_active = 0;
    check("R4 bus wake", {osc_en, rd_data[3]}, 8'h02);

    // R10 wake coincident with suspend write
    gpio_wake = 1; wr(8'h09);
    check("R10 suspended one cycle", {7'b0, rd_data[3]}, 8'h01);
    cyc(); gpio_wake = 0;
    check("R10 then woke", {7'b0, rd_data[3]}, 8'h00);

    // R5 partial count cleared by suspend
    ticks(100);
    wr(8'h09);
    rcpin_wake = 1; cyc(); rcpin_wake = 0;
    ticks(255);
    check("R5 count restarted", {7'b0, core_ready}, 8'h00);
    ticks(1);
    check("R5 ready after restart", {7'b0, core_ready}, 8'h01);

    // R1 R2 second reset
    do_reset();
    check("R1 reset again", rd_data, 8'h19);
    gpio_wake = 1; rcpin_wake = 1; repeat (2) cyc(); idle();
    check("R2 lock again", {7'b0, osc_en}, 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule